// File: doc/BRIEF.md
# Segmented Fixed-Latency Pipeline Delay

This block delays a data word of parameterized width by exactly `LATENCY` clock cycles. It balances pipeline depth between parallel paths of a datapath, so that two results computed with different numbers of register stages arrive together. The latency is fixed when the block is built and cannot change at run time.

The delay is built from a chain of segments. Each segment is a shift register read at a fixed tap address, followed by one output flip-flop. This is the same shape that a LUT-based shift-register fabric would infer, and the flip-flop at the end of each segment keeps the slow setup time of the shift storage out of the downstream timing path. Two inputs are optional and chosen by parameter: a synchronous clear and a clock enable. The clear always wins over the enable. With `LATENCY` of zero the block becomes a plain wire.

Top module: `pdl_delay_line`

## Requirements
- R1: With the enable held high (or absent), `dout` equals the `din` value that was sampled exactly `LATENCY` rising clock edges earlier.
- R2: With `LATENCY` = 0, `dout` follows `din` combinationally in the same cycle. Building with `LATENCY` = 0 and `HAS_EN` = 1 stops elaboration with an error.
- R3: With `LATENCY` = 1, the block is one register per data bit. After each enabled edge, `dout` holds the `din` sampled at that edge.
- R4: The latency is divided into segments of at most 33 cycles, filled greedily from the input side. A segment of span S uses a shift stage of S-1 cycles, read at tap address S-2, plus one output register; a segment of span 1 is the register alone. For `LATENCY` = 64 this gives 32+1 and 30+1, with the second tap at address 29. The overall delay is correct for spans of 1, 2, 33 and 34 and for a two-segment latency of 64.
- R5: While `en` is low (with `HAS_EN` = 1) and `rst` is low, every stage holds its contents and `dout` does not change.
- R6: With `HAS_RST` = 1, a high `rst` at a rising edge clears every stage to zero regardless of `en`. `dout` is zero in the cycle after that edge.
- R7: After a clear, `dout` stays zero until `LATENCY` new samples have been accepted. No word sampled before the clear ever reaches `dout`.
- R8: All stages start at zero. While `rst` is held high, `dout` is zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high clear. Ignored when `HAS_RST` = 0 |
| en | input | 1 | Clock enable; stages advance only when it is high. Ignored when `HAS_EN` = 0 |
| din | input | WIDTH | Data word entering the delay line |
| dout | output | WIDTH | Data word leaving the delay line |

## Verification
A sample counts toward the delay only at an edge where it is accepted, meaning `en` is high and `rst` is low. The word accepted N edges ago is therefore due at `dout` after exactly `LATENCY` further accepted edges, and for `LATENCY` = 0 it is due in the same cycle.

The bench keeps one history of accepted words, newest first, and empties it on every clear. For each instance it reads the entry at position `LATENCY`-1, or zero if the history is not that long yet, and compares it on every falling edge, half a cycle after the registers update. Inputs change only after that comparison, so each check sees the state produced by the edge just before it.

// File: rtl/pdl_pkg.sv
package pdl_pkg;

    // Longest span a single segment covers: shift storage plus one flop.
    localparam int SEG_SPAN  = 33;
    localparam int SHIFT_MAX = SEG_SPAN - 1;

    // Control applied to every stage in the same cycle.
    typedef struct packed {
        logic clr;   // synchronous clear, wins over advance
        logic adv;   // shift one position
    } stage_ctl_t;

    function automatic int seg_count(input int lat);
        return (lat + SEG_SPAN - 1) / SEG_SPAN;
    endfunction

    // Span of segment idx, filling from the input side.
    function automatic int seg_span(input int lat, input int idx);
        int rem;
        rem = lat - idx * SEG_SPAN;
        return (rem > SEG_SPAN) ? SEG_SPAN : rem;
    endfunction

    // Read address of the shift stage: its delay minus one.
    function automatic int seg_tap(input int span);
        return span - 2;
    endfunction

endpackage

// File: rtl/pdl_shift_stage.sv
module pdl_shift_stage
    import pdl_pkg::*;
#(
    parameter int WIDTH = 16,
    parameter int DEPTH = 32
) (
    input  logic                          clk,
    input  stage_ctl_t                    ctl,
    input  logic [WIDTH-1:0]              d,
    input  logic [(DEPTH>1 ? $clog2(DEPTH) : 1)-1:0] tap,
    output logic [WIDTH-1:0]              q
);
    logic [WIDTH-1:0] cells [DEPTH] = '{default: '0};

    always_ff @(posedge clk) begin
        if (ctl.clr) begin
            for (int i = 0; i < DEPTH; i++) cells[i] <= '0;
        end else if (ctl.adv) begin
            cells[0] <= d;
            for (int i = 1; i < DEPTH; i++) cells[i] <= cells[i-1];
        end
    end

    // Addressed read: delay through this stage is tap + 1.
    assign q = cells[tap];

endmodule

// File: rtl/pdl_segment.sv
module pdl_segment
    import pdl_pkg::*;
#(
    parameter int WIDTH = 16,
    parameter int SPAN  = SEG_SPAN
) (
    input  logic             clk,
    input  stage_ctl_t       ctl,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    localparam int SHIFT_DLY = SPAN - 1;
    localparam int TAP       = (SHIFT_DLY > 0) ? seg_tap(SPAN) : 0;
    localparam int AW        = (SHIFT_DLY > 1) ? $clog2(SHIFT_DLY) : 1;

    logic [WIDTH-1:0] to_flop;
    logic [WIDTH-1:0] out_q = '0;

    generate
        if (SHIFT_DLY > 0) begin : g_shift
            localparam logic [AW-1:0] TAP_ADDR = AW'(TAP);
            pdl_shift_stage #(
                .WIDTH (WIDTH),
                .DEPTH (SHIFT_DLY)
            ) u_shift (
                .clk (clk),
                .ctl (ctl),
                .d   (d),
                .tap (TAP_ADDR),
                .q   (to_flop)
            );
        end else begin : g_direct
            assign to_flop = d;
        end
    endgenerate

    // Terminating register of the segment.
    always_ff @(posedge clk) begin
        if (ctl.clr)      out_q <= '0;
        else if (ctl.adv) out_q <= to_flop;
    end

    assign q = out_q;

endmodule

// File: rtl/pdl_delay_line.sv
module pdl_delay_line
    import pdl_pkg::*;
#(
    parameter int WIDTH   = 16,
    parameter int LATENCY = 64,
    parameter bit HAS_RST = 1'b1,
    parameter bit HAS_EN  = 1'b1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);
    localparam int NSEG = seg_count(LATENCY);

    stage_ctl_t ctl;
    assign ctl.clr = rst & HAS_RST;
    assign ctl.adv = en | ~HAS_EN;

    generate
        if (LATENCY < 0) begin : g_bad_neg
            $error("pdl_delay_line: LATENCY must be non-negative");
        end
        if (LATENCY == 0) begin : g_wire
            if (HAS_EN) begin : g_bad_en
                $error("pdl_delay_line: zero latency cannot have an enable");
            end
            assign dout = din;
        end else begin : g_chain
            logic [WIDTH-1:0] link [NSEG+1];
            assign link[0] = din;
            for (genvar g = 0; g < NSEG; g++) begin : g_seg
                pdl_segment #(
                    .WIDTH (WIDTH),
                    .SPAN  (seg_span(LATENCY, g))
                ) u_seg (
                    .clk (clk),
                    .ctl (ctl),
                    .d   (link[g]),
                    .q   (link[g+1])
                );
            end
            assign dout = link[NSEG];
        end
    endgenerate

endmodule

// File: rtl/pdl_delay_line_chk.sv
module pdl_delay_line_chk #(
    parameter int WIDTH   = 16,
    parameter int LATENCY = 64,
    parameter bit HAS_RST = 1'b1,
    parameter bit HAS_EN  = 1'b1
) (
    input logic             clk,
    input logic             rst,
    input logic             en,
    input logic [WIDTH-1:0] din,
    input logic [WIDTH-1:0] dout
);
    logic clr_s, adv_s;
    assign clr_s = rst && HAS_RST;
    assign adv_s = en || !HAS_EN;

    // Accepted samples since the last clear, saturating at LATENCY.
    int unsigned taken = 0;
    always_ff @(posedge clk) begin
        if (clr_s)                                 taken <= 0;
        else if (adv_s && taken < LATENCY)         taken <= taken + 1;
    end

    a_r5_hold_without_enable: assert property (@(posedge clk) disable iff (clr_s)
        (HAS_EN && LATENCY > 0 && !en) |=> $stable(dout));

    a_r6_clear_gives_zero: assert property (@(posedge clk) disable iff (clr_s)
        (HAS_RST && LATENCY > 0 && $fell(rst)) |-> (dout == '0));

    a_r7_no_stale_data: assert property (@(posedge clk) disable iff (clr_s)
        (LATENCY > 0 && taken < LATENCY) |-> (dout == '0));

    a_r3_single_register: assert property (@(posedge clk) disable iff (clr_s)
        (LATENCY == 1 && adv_s) |=> (dout == $past(din)));

endmodule

bind pdl_delay_line pdl_delay_line_chk #(
    .WIDTH   (WIDTH),
    .LATENCY (LATENCY),
    .HAS_RST (HAS_RST),
    .HAS_EN  (HAS_EN)
) u_chk (.*);

// File: tb/pdl_delay_line_bench.sv
module pdl_delay_line_bench;
    localparam int W = 16;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic en  = 1'b0;
    logic [W-1:0] din = '0;
    logic [W-1:0] dout0, dout1, dout2, dout33, dout34, dout64;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;
    string phase = "R8";

    always #5 clk = ~clk;

    pdl_delay_line #(.WIDTH(W), .LATENCY(0),  .HAS_RST(1'b1), .HAS_EN(1'b0))
        u_pdl_delay_line_l0  (.clk(clk), .rst(rst), .en(en), .din(din), .dout(dout0));
    pdl_delay_line #(.WIDTH(W), .LATENCY(1))
        u_pdl_delay_line_l1  (.clk(clk), .rst(rst), .en(en), .din(din), .dout(dout1));
    pdl_delay_line #(.WIDTH(W), .LATENCY(2))
        u_pdl_delay_line_l2  (.clk(clk), .rst(rst), .en(en), .din(din), .dout(dout2));
    pdl_delay_line #(.WIDTH(W), .LATENCY(33))
        u_pdl_delay_line_l33 (.clk(clk), .rst(rst), .en(en), .din(din), .dout(dout33));
    pdl_delay_line #(.WIDTH(W), .LATENCY(34))
        u_pdl_delay_line_l34 (.clk(clk), .rst(rst), .en(en), .din(din), .dout(dout34));
    pdl_delay_line #(.WIDTH(W), .LATENCY(64))
        u_pdl_delay_line     (.clk(clk), .rst(rst), .en(en), .din(din), .dout(dout64));

    // Reference: accepted words, newest first, emptied by a clear.
    logic [W-1:0] hist [$];
    always @(posedge clk) begin
        if (rst) begin
            hist.delete();
        end else if (en) begin
            hist.push_front(din);
            if (hist.size() > 80) void'(hist.pop_back());
        end
    end

    function automatic logic [W-1:0] expect_at(input int lat);
        if (lat == 0) return din;
        if (hist.size() >= lat) return hist[lat-1];
        return '0;
    endfunction

    task automatic check(input string req, input string who,
                         input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: got %h expected %h at %0t", req, who, act, exp, $time);
        end
    endtask

    task automatic check_all();
        string seg_tag;
        seg_tag = (phase == "R1") ? "R4" : phase;
        // The zero-latency instance has no enable, so only the
        // combinational path applies to it.
        check("R2", "L0", dout0, din);
        check((phase == "R1") ? "R3" : phase, "L1", dout1, expect_at(1));
        check(seg_tag, "L2",  dout2,  expect_at(2));
        check(seg_tag, "L33", dout33, expect_at(33));
        check(seg_tag, "L34", dout34, expect_at(34));
        check((phase == "R1") ? "R1" : phase, "L64", dout64, expect_at(64));
    endtask

    task automatic step(input logic r, input logic e, input logic [W-1:0] d);
        @(negedge clk);
        check_all();
        rst = r;
        en  = e;
        din = d;
    endtask

    initial begin
        // R8: held in reset, outputs zero
        phase = "R8";
        for (int i = 0; i < 4; i++) step(1'b1, 1'b1, W'($urandom));

        // R1 / R3 / R4: continuous enable, random data
        phase = "R1";
        for (int i = 0; i < 300; i++) step(1'b0, 1'b1, W'($urandom));

        // R5: random enable gaps
        phase = "R5";
        for (int i = 0; i < 800; i++) step(1'b0, ($urandom % 2) == 0, W'($urandom));

        // R6: random clears against both enable values
        phase = "R6";
        for (int i = 0; i < 1200; i++)
            step(($urandom % 25) == 0, ($urandom % 3) != 0, W'($urandom));

        // R7: fill with nonzero data, clear, then stream new data
        phase = "R7";
        for (int i = 0; i < 80; i++) step(1'b0, 1'b1, 16'hA5A5 ^ W'(i));
        step(1'b1, 1'b0, 16'hFFFF);
        for (int i = 0; i < 100; i++) step(1'b0, ($urandom % 4) != 0, W'(i + 1));

        @(negedge clk);
        check_all();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(10 * 200000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: run did not complete, got running expected done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule